// File: doc/BRIEF.md
# Shift-Register Raster Timing Generator

This block produces horizontal sync, vertical sync, display-enable and blanking strobes for a raster display. Binary counters are not used. A 16-bit maximal-length linear feedback shift register walks through the pixels of a line, and a second one walks through the lines of a frame. Each step needs only a shift and a four-input XOR, so the counters stay shallow at high pixel rates. Every timing boundary is a 16-bit compare value that matches a register state, not a binary count. The host converts counts to register states before it writes them.

A byte-wide write port loads the compare values and an output-mode byte. Any write to a compare byte restarts both sequences at their seed. The output-mode byte selects one of four behaviours: normal output, blanked with both syncs stopped, standby, and a latched powerdown. Leaving powerdown takes a timing write first.

Top module: `lvt_top`

## Requirements
- R1: Both sequence registers are seeded with 0xFFFF. Each step shifts the state left by one and places the XOR of bits 15, 4, 2 and 1 into bit 0. While reset is asserted and just after it, hsync, vsync and display-enable are low, blank is high, and the output mode is 0x00.
- R2: Compare values are 16 bits wide and written one byte at a time. The high byte sits at the odd address and the low byte at the address after it. The addresses are: pixel window open 0x01, pixel window close 0x03, line window open 0x05, line window close 0x07, line end 0x09, hsync open 0x0B, hsync close 0x0D, frame end 0x11, vsync open 0x13, vsync close 0x15. Every write to one of these twenty bytes returns both sequences to 0xFFFF (count 0) on that clock edge.
- R3: When the pixel sequence equals the line-end value, the next step returns it to 0xFFFF. A line therefore lasts N+1 clocks, where N is the binary count behind the line-end value.
- R4: The line sequence steps only on the clock where the pixel sequence wraps. When it equals the frame-end value on such a step, it returns to 0xFFFF.
- R5: hsync is high for pixel counts from the hsync open value up to, but not including, the hsync close value. vsync does the same on line counts between the vsync open and close values.
- R6: In mode 0x00, display-enable is high only when the pixel count lies in [pixel open, pixel close) and the line count lies in [line open, line close). In this mode blank is the inverse of display-enable.
- R7: Mode 0x01 holds both syncs and display-enable low and blank high, while the sequences keep running. Any mode code other than 0x00, 0x05 and 0x07 behaves the same way. Writing 0x00 again brings back output that follows the uninterrupted timing.
- R8: Mode 0x05 (standby) holds hsync and display-enable low and blank high, while vsync keeps following the line timing.
- R9: Mode 0x07 (powerdown) drives all four outputs low and freezes both sequences. Writing 0x00 releases powerdown only if a compare-byte write has happened since powerdown was entered. Without that write, 0x00 leaves the block in powerdown.
- R10: Writes to addresses outside the compare bytes and the mode byte (for example 0x0F, 0x10, 0x17, 0x1B) neither restart the sequences nor change any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for the byte port |
| wr_addr_i | input | 8 | Byte address |
| wr_data_i | input | 8 | Byte data |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| de_o | output | 1 | Display enable |
| blank_o | output | 1 | Blanking strobe |

## Verification
If a sequence register holds a wrong state, it misses a compare. Within one line a missed line-end match stretches the line, which shifts every later hsync edge and display-enable window. A wrong line state shows up one frame later as a displaced vsync. The bench predicts each output on every clock from binary counts and compares it against the design, so a one-cycle slip appears on the first shifted edge. Powerdown latching is checked by confirming that outputs stay low after a bare 0x00 write, and that timing resumes from count 0 after the compare write and the release.

// File: rtl/lvt_pkg.sv
package lvt_pkg;
    localparam int CW    = 16;
    localparam int AW    = 8;
    localparam int DW    = 8;
    localparam int NCMP  = 10;
    localparam int NWIN  = 2;

    localparam logic [CW-1:0] SEED = '1;

    // compare slot indices
    localparam int C_XDS  = 0;
    localparam int C_XDE  = 1;
    localparam int C_YDS  = 2;
    localparam int C_YDE  = 3;
    localparam int C_XEND = 4;
    localparam int C_HSS  = 5;
    localparam int C_HSE  = 6;
    localparam int C_YEND = 7;
    localparam int C_VSS  = 8;
    localparam int C_VSE  = 9;

    // window indices inside an axis
    localparam int W_DISP = 0;
    localparam int W_SYNC = 1;

    localparam logic [AW-1:0] MODE_ADDR = 8'h1F;

    typedef enum logic [DW-1:0] {
        MODE_RUN   = 8'h00,
        MODE_BLANK = 8'h01,
        MODE_STBY  = 8'h05,
        MODE_OFF   = 8'h07
    } mode_e;

    // High-byte address of compare slot idx; slots 0..6 are packed from 0x01,
    // slots 7..9 from 0x11 (0x0F/0x10 are left to other data).
    function automatic logic [AW-1:0] cmp_addr(input int idx);
        if (idx < 7) return AW'(1 + 2 * idx);
        else         return AW'(17 + 2 * (idx - 7));
    endfunction

    function automatic logic [CW-1:0] lfsr_next(input logic [CW-1:0] s);
        return {s[CW-2:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
    endfunction
endpackage

// File: rtl/lvt_regs.sv
module lvt_regs
    import lvt_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [AW-1:0]            wr_addr_i,
    input  logic [DW-1:0]            wr_data_i,
    output logic [NCMP-1:0][CW-1:0]  cmp_o,
    output logic [DW-1:0]            mode_o,
    output logic                     pd_o,
    output logic                     restart_o
);
    typedef struct packed {
        logic [NCMP-1:0][CW-1:0] cmp;
        logic [DW-1:0]           mode;
        logic                    pd;
        logic                    armed;
    } regs_t;

    regs_t q, d;
    logic [NCMP-1:0] hit_hi, hit_lo;
    logic            mode_wr;

    for (genvar g = 0; g < NCMP; g++) begin : g_dec
        assign hit_hi[g] = wr_en_i && (wr_addr_i == cmp_addr(g));
        assign hit_lo[g] = wr_en_i && (wr_addr_i == cmp_addr(g) + 8'd1);
    end

    assign mode_wr   = wr_en_i && (wr_addr_i == MODE_ADDR);
    assign restart_o = |{hit_hi, hit_lo};

    always_comb begin
        d = q;
        for (int i = 0; i < NCMP; i++) begin
            if (hit_hi[i]) d.cmp[i][CW-1:DW] = wr_data_i;
            if (hit_lo[i]) d.cmp[i][DW-1:0]  = wr_data_i;
        end
        if (restart_o && q.pd) d.armed = 1'b1;
        if (mode_wr) begin
            d.mode = wr_data_i;
            if (wr_data_i == MODE_OFF) begin
                d.pd    = 1'b1;
                d.armed = 1'b0;
            end else if (wr_data_i == MODE_RUN && q.armed) begin
                d.pd    = 1'b0;
                d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cmp_o  = q.cmp;
    assign mode_o = q.mode;
    assign pd_o   = q.pd;

    p_pd_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && wr_data_i == MODE_OFF) |=> pd_o);

    p_pd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_o && !q.armed && !restart_o) |=> pd_o);
endmodule

// File: rtl/lvt_axis.sv
module lvt_axis
    import lvt_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step_i,
    input  logic                     restart_i,
    input  logic [CW-1:0]            end_i,
    input  logic [NWIN-1:0][CW-1:0]  win_open_i,
    input  logic [NWIN-1:0][CW-1:0]  win_close_i,
    output logic [CW-1:0]            cnt_o,
    output logic                     wrap_o,
    output logic [NWIN-1:0]          win_o
);
    typedef struct packed {
        logic [CW-1:0]   cnt;
        logic [NWIN-1:0] win;
    } axis_t;

    axis_t q, d;
    logic [CW-1:0] nxt;

    always_comb begin
        wrap_o = step_i && (q.cnt == end_i);
        if (restart_i || wrap_o) nxt = SEED;
        else if (step_i)         nxt = lfsr_next(q.cnt);
        else                     nxt = q.cnt;
        d.cnt = nxt;
        for (int w = 0; w < NWIN; w++) begin
            if (nxt == win_open_i[w])       d.win[w] = 1'b1;
            else if (nxt == win_close_i[w]) d.win[w] = 1'b0;
            else if (restart_i)             d.win[w] = 1'b0;
            else                            d.win[w] = q.win[w];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{cnt: SEED, win: '0};
        else        q <= d;
    end

    assign cnt_o = q.cnt;
    assign win_o = q.win;

    p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cnt_o == SEED));

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !restart_i && cnt_o == end_i) |=> (cnt_o == SEED));

    p_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !restart_i && cnt_o != end_i) |=> (cnt_o[CW-1:1] == $past(cnt_o[CW-2:0])));

    p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !restart_i) |=> $stable(cnt_o));
endmodule

// File: rtl/lvt_top.sv
module lvt_top
    import lvt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [7:0]    wr_addr_i,
    input  logic [7:0]    wr_data_i,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic          blank_o
);
    logic [NCMP-1:0][CW-1:0] cmp;
    logic [DW-1:0]           mode;
    logic                    pd, restart;
    logic [CW-1:0]           h_cnt, v_cnt;
    logic                    h_wrap, v_wrap;
    logic [NWIN-1:0]         h_win, v_win;

    lvt_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .cmp_o     (cmp),
        .mode_o    (mode),
        .pd_o      (pd),
        .restart_o (restart)
    );

    lvt_axis u_h (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_i      (!pd),
        .restart_i   (restart),
        .end_i       (cmp[C_XEND]),
        .win_open_i  ({cmp[C_HSS], cmp[C_XDS]}),
        .win_close_i ({cmp[C_HSE], cmp[C_XDE]}),
        .cnt_o       (h_cnt),
        .wrap_o      (h_wrap),
        .win_o       (h_win)
    );

    lvt_axis u_v (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_i      (h_wrap),
        .restart_i   (restart),
        .end_i       (cmp[C_YEND]),
        .win_open_i  ({cmp[C_VSS], cmp[C_YDS]}),
        .win_close_i ({cmp[C_VSE], cmp[C_YDE]}),
        .cnt_o       (v_cnt),
        .wrap_o      (v_wrap),
        .win_o       (v_win)
    );

    always_comb begin
        hsync_o = 1'b0;
        vsync_o = 1'b0;
        de_o    = 1'b0;
        blank_o = 1'b1;
        if (pd) begin
            blank_o = 1'b0;
        end else begin
            case (mode)
                MODE_RUN: begin
                    hsync_o = h_win[W_SYNC];
                    vsync_o = v_win[W_SYNC];
                    de_o    = h_win[W_DISP] & v_win[W_DISP];
                    blank_o = ~(h_win[W_DISP] & v_win[W_DISP]);
                end
                MODE_STBY: vsync_o = v_win[W_SYNC];
                default: ;
            endcase
        end
    end

    p_vstep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!h_wrap && !restart) |=> $stable(v_cnt));

    p_pd_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pd |-> !(hsync_o || vsync_o || de_o || blank_o));

    p_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pd && mode == MODE_RUN) |-> (blank_o != de_o));

    p_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (v_wrap && !restart) |=> (v_cnt == SEED && h_cnt == SEED));
endmodule

// File: tb/lvt_top_tb_top.sv
module lvt_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       hsync, vsync, de, blank;

    always #5 clk = ~clk;

    lvt_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .hsync_o   (hsync),
        .vsync_o   (vsync),
        .de_o      (de),
        .blank_o   (blank)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // binary reference model
    int hc = 0, vc = 0;
    int xds, xde, yds, yde, hend, hss, hse, yend, vss, vse;
    logic [7:0] m_mode = 8'h00;
    bit m_pd = 1'b0, m_arm = 1'b0;

    logic [3:0] exp_q[$];
    string      tag_q[$];

    function automatic logic [15:0] lfsr_of(input int n);
        logic [15:0] s = 16'hFFFF;
        for (int i = 0; i < n; i++) s = {s[14:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
        return s;
    endfunction

    function automatic bit is_timing(input logic [7:0] a);
        return (a >= 8'h01 && a <= 8'h0E) || (a >= 8'h11 && a <= 8'h16);
    endfunction

    function automatic logic [3:0] expected();
        bit hs_w = (hc >= hss) && (hc < hse);
        bit vs_w = (vc >= vss) && (vc < vse);
        bit dp   = (hc >= xds) && (hc < xde) && (vc >= yds) && (vc < yde);
        if (m_pd)                return 4'b0000;
        if (m_mode == 8'h00)     return {hs_w, vs_w, dp, !dp};
        if (m_mode == 8'h05)     return {1'b0, vs_w, 1'b0, 1'b1};
        return 4'b0001;
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: {hsync,vsync,de,blank} got %b expected %b at t=%0t", tag, act, exp, $time);
        end
    endtask

    // monitor: pops expected items and compares away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) check(tag_q.pop_front(), {hsync, vsync, de, blank}, exp_q.pop_front());
        end
    end

    // driver: one clock cycle, model update, optional push of the expectation
    task automatic cyc(input bit we, input logic [7:0] a, input logic [7:0] dat,
                       input bit chk, input string tag);
        bit was_pd;
        wr_en = we; wr_addr = a; wr_data = dat;
        @(posedge clk);
        was_pd = m_pd;
        if (we && is_timing(a)) begin
            hc = 0; vc = 0;
            if (was_pd) m_arm = 1'b1;
        end else if (!was_pd) begin
            if (hc == hend) begin
                hc = 0;
                vc = (vc == yend) ? 0 : vc + 1;
            end else hc++;
        end
        if (we && a == 8'h1F) begin
            m_mode = dat;
            if (dat == 8'h07) begin m_pd = 1'b1; m_arm = 1'b0; end
            else if (dat == 8'h00 && m_arm) begin m_pd = 1'b0; m_arm = 1'b0; end
        end
        @(negedge clk);
        wr_en = 1'b0;
        if (chk) begin
            exp_q.push_back(expected());
            tag_q.push_back(tag);
        end
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 8'h00, 1'b1, tag);
    endtask

    task automatic wr16(input logic [7:0] a, input int cnt);
        logic [15:0] v = lfsr_of(cnt);
        cyc(1'b1, a, v[15:8], 1'b0, "R2");
        cyc(1'b1, a + 8'd1, v[7:0], 1'b0, "R2");
    endtask

    task automatic configure(input int p_xds, p_xde, p_yds, p_yde, p_hend,
                             p_hss, p_hse, p_yend, p_vss, p_vse);
        xds = p_xds; xde = p_xde; yds = p_yds; yde = p_yde; hend = p_hend;
        hss = p_hss; hse = p_hse; yend = p_yend; vss = p_vss; vse = p_vse;
        wr16(8'h01, xds);  wr16(8'h03, xde);
        wr16(8'h05, yds);  wr16(8'h07, yde);
        wr16(8'h09, hend); wr16(8'h0B, hss);
        wr16(8'h0D, hse);  wr16(8'h11, yend);
        wr16(8'h13, vss);  wr16(8'h15, vse);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 in reset", {hsync, vsync, de, blank}, 4'b0001);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R1 after reset", {hsync, vsync, de, blank}, 4'b0001);
        end

        // R3 R4 R5 R6: 12-clock lines, 6-line frames
        configure(4, 10, 2, 5, 11, 1, 3, 5, 0, 1);
        cyc(1'b1, 8'h1F, 8'h00, 1'b1, "R6 mode run");
        run(160, "R3 R4 R5 R6 frame A");

        // R10: writes to unrelated addresses
        cyc(1'b1, 8'h0F, 8'h12, 1'b1, "R10 addr 0x0F");
        cyc(1'b1, 8'h10, 8'h34, 1'b1, "R10 addr 0x10");
        cyc(1'b1, 8'h17, 8'h56, 1'b1, "R10 addr 0x17");
        cyc(1'b1, 8'h1B, 8'h78, 1'b1, "R10 addr 0x1B");
        run(30, "R10 timing continues");

        // R7: sync-off blanking and an unlisted code
        cyc(1'b1, 8'h1F, 8'h01, 1'b1, "R7 mode 0x01");
        run(40, "R7 blanked");
        cyc(1'b1, 8'h1F, 8'h03, 1'b1, "R7 mode 0x03");
        run(20, "R7 unlisted code");
        cyc(1'b1, 8'h1F, 8'h00, 1'b1, "R7 back to run");
        run(40, "R7 resumed timing");

        // R8: standby keeps vsync
        cyc(1'b1, 8'h1F, 8'h05, 1'b1, "R8 mode 0x05");
        run(100, "R8 standby");
        cyc(1'b1, 8'h1F, 8'h00, 1'b1, "R8 back to run");
        run(20, "R8 resumed timing");

        // R9: powerdown latch
        cyc(1'b1, 8'h1F, 8'h07, 1'b1, "R9 mode 0x07");
        run(30, "R9 powerdown");
        cyc(1'b1, 8'h1F, 8'h00, 1'b1, "R9 bare release");
        run(30, "R9 still down");
        wr16(8'h09, hend);
        run(10, "R9 after timing write");
        cyc(1'b1, 8'h1F, 8'h00, 1'b1, "R9 release");
        run(100, "R9 resumed from count 0");

        // R2 R3 R4 R5 R6: a second geometry
        configure(6, 18, 3, 7, 19, 1, 5, 7, 0, 2);
        run(340, "R2 R3 R4 R5 R6 frame B");

        wait (exp_q.size() == 0);
        @(negedge clk);
        #2;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule